// File: doc/BRIEF.md
# LED Driver Power-Up Sequencer

This block takes a 16-channel constant-current LED sink driver from reset into grayscale operation. The driver is loaded over a bit-serial link. That link has a serial data line, a serial clock, a latch strobe, a blanking line, a programming-mode select (high selects dot-correction loading, low selects grayscale loading) and a dot-correction source select. After a one-cycle start request, the block does four things in order. It fills every channel's dot-correction register with its maximum value and latches it. It switches the driver into grayscale mode and flushes the grayscale shift register with zeros, then latches again. It gives the one extra serial clock that the driver needs after it leaves dot-correction mode. Finally it raises a done flag.

The outputs are all registered and depend only on the system clock, so the serial link runs at half the system clock rate. The host logic that streams pixel data waits for done and then takes over the link. While the sequence is running, the block ignores any further start requests. There is no data stream into or out of the block, so every pin is a plain control or status signal and none of them uses a handshake.

Top module: `led_drv_init_seq`

## Requirements
- R1: After reset, blank_o, prog_mode_o and dc_src_o are 1, and sdata_o, sclk_o, latch_o and done_o are 0. Without a start request, no sclk_o or latch_o pulse occurs.
- R2: After start_i is sampled high, exactly CHANNELS*DC_BITS (96) sclk_o pulses occur with sdata_o=1 and prog_mode_o=1. Exactly one latch_o pulse follows them.
- R3: After that first latch, prog_mode_o is 0. Exactly CHANNELS*GS_BITS (192) sclk_o pulses then occur with sdata_o=0, and a second latch_o pulse follows them.
- R4: After the second latch, exactly one more sclk_o pulse occurs before done_o rises. No further pulse follows it.
- R5: blank_o and dc_src_o stay 1 on every cycle, including during the sequence and after done.
- R6: Every sclk_o and latch_o pulse is high for one cycle and is followed by at least one low cycle. sclk_o and latch_o are never high in the same cycle.
- R7: sdata_o changes only in a cycle where sclk_o is low and was low in the previous cycle. prog_mode_o changes only while both sclk_o and latch_o are low.
- R8: done_o rises 2*(96+192+1)+4 = 582 cycles after the clock edge that samples start_i. It stays 1 until start_i is sampled high again, which clears it and starts a new sequence.
- R9: If start_i is sampled high while a sequence is running, the block ignores it. The pulse counts and the time at which done_o rises are the same as in a run with no restart request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request; the block accepts it only when idle or done |
| sdata_o | output | 1 | Serial data to the driver |
| sclk_o | output | 1 | Serial shift clock to the driver |
| latch_o | output | 1 | Latch strobe that transfers the shift register contents |
| blank_o | output | 1 | Blanking; high turns all channel outputs off |
| prog_mode_o | output | 1 | 1 selects dot-correction loading, 0 selects grayscale loading |
| dc_src_o | output | 1 | Dot-correction source select; 1 takes values from the register |
| done_o | output | 1 | High from the end of the sequence until the next start |

## Verification
On every cycle, the assertions check the pulse shape (one high cycle, no overlap) and that data and mode changes occur only while the clock is low. They also check that done holds until a start, and they check the pulse count at each latch and at done against a counter in the checker. The bench scenarios are the only way to show the exact cycle on which done rises, that a restart request in mid-sequence leaves the counts unchanged, and that nothing moves while the block idles. The same holds for a second run after done and for the data value seen in each phase.

// File: rtl/led_init_pkg.sv
package led_init_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DC_SHIFT,
    ST_DC_LATCH,
    ST_GS_SHIFT,
    ST_GS_LATCH,
    ST_TAIL_CLK,
    ST_DONE
  } init_state_e;
endpackage

// File: rtl/init_pulse_train.sv
// Emits LIMIT pulses, each one cycle low then one cycle high, while enabled.
module init_pulse_train #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [CW-1:0] limit_i,
  output logic          pulse_o,
  output logic          last_o
);
  logic          pulse_q;
  logic [CW-1:0] cnt_q;

  assign last_o  = en_i && pulse_q && (cnt_q == limit_i - CW'(1));
  assign pulse_o = pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!en_i || last_o) begin
      pulse_q <= 1'b0;
      cnt_q   <= '0;
    end else if (pulse_q) begin
      pulse_q <= 1'b0;
      cnt_q   <= cnt_q + CW'(1);
    end else begin
      pulse_q <= 1'b1;
    end
  end
endmodule

// File: rtl/init_seq_fsm.sv
module init_seq_fsm
  import led_init_pkg::*;
#(
  parameter int DC_PULSES = 96,
  parameter int GS_PULSES = 192,
  parameter int CW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          sclk_last_i,
  input  logic          latch_last_i,
  output logic          sclk_en_o,
  output logic [CW-1:0] sclk_limit_o,
  output logic          latch_en_o,
  output logic          sdata_o,
  output logic          prog_mode_o,
  output logic          done_o
);
  init_state_e state_q;

  always_comb begin
    sclk_en_o    = 1'b0;
    latch_en_o   = 1'b0;
    sclk_limit_o = CW'(1);
    case (state_q)
      ST_DC_SHIFT: begin sclk_en_o = 1'b1; sclk_limit_o = CW'(DC_PULSES); end
      ST_GS_SHIFT: begin sclk_en_o = 1'b1; sclk_limit_o = CW'(GS_PULSES); end
      ST_TAIL_CLK: begin sclk_en_o = 1'b1; sclk_limit_o = CW'(1); end
      ST_DC_LATCH, ST_GS_LATCH: latch_en_o = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      sdata_o     <= 1'b0;
      prog_mode_o <= 1'b1;
      done_o      <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: if (start_i) begin
          state_q     <= ST_DC_SHIFT;
          sdata_o     <= 1'b1;
          prog_mode_o <= 1'b1;
          done_o      <= 1'b0;
        end
        ST_DC_SHIFT: if (sclk_last_i) state_q <= ST_DC_LATCH;
        ST_DC_LATCH: if (latch_last_i) begin
          state_q     <= ST_GS_SHIFT;
          sdata_o     <= 1'b0;
          prog_mode_o <= 1'b0;
        end
        ST_GS_SHIFT: if (sclk_last_i) state_q <= ST_GS_LATCH;
        ST_GS_LATCH: if (latch_last_i) state_q <= ST_TAIL_CLK;
        ST_TAIL_CLK: if (sclk_last_i) begin
          state_q <= ST_DONE;
          done_o  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/led_drv_init_seq.sv
module led_drv_init_seq #(
  parameter int CHANNELS = 16,
  parameter int DC_BITS  = 6,
  parameter int GS_BITS  = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic sdata_o,
  output logic sclk_o,
  output logic latch_o,
  output logic blank_o,
  output logic prog_mode_o,
  output logic dc_src_o,
  output logic done_o
);
  localparam int DC_PULSES = CHANNELS * DC_BITS;
  localparam int GS_PULSES = CHANNELS * GS_BITS;
  localparam int MAX_PULSES = (DC_PULSES > GS_PULSES) ? DC_PULSES : GS_PULSES;
  localparam int CW = $clog2(MAX_PULSES + 1);

  logic          sclk_en, latch_en, sclk_last, latch_last;
  logic [CW-1:0] sclk_limit;
  logic          ctrl_q;

  init_seq_fsm #(
    .DC_PULSES(DC_PULSES), .GS_PULSES(GS_PULSES), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .sclk_last_i(sclk_last), .latch_last_i(latch_last),
    .sclk_en_o(sclk_en), .sclk_limit_o(sclk_limit), .latch_en_o(latch_en),
    .sdata_o(sdata_o), .prog_mode_o(prog_mode_o), .done_o(done_o)
  );

  init_pulse_train #(.CW(CW)) u_sclk (
    .clk(clk), .rst_n(rst_n), .en_i(sclk_en), .limit_i(sclk_limit),
    .pulse_o(sclk_o), .last_o(sclk_last)
  );

  init_pulse_train #(.CW(1)) u_latch (
    .clk(clk), .rst_n(rst_n), .en_i(latch_en), .limit_i(1'b1),
    .pulse_o(latch_o), .last_o(latch_last)
  );

  // Blanking and register-sourced dot correction are held throughout.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= 1'b1;
    else        ctrl_q <= 1'b1;
  end
  assign blank_o  = ctrl_q;
  assign dc_src_o = ctrl_q;
endmodule

// File: rtl/led_drv_init_seq_chk.sv
module led_drv_init_seq_chk #(
  parameter int CHANNELS = 16,
  parameter int DC_BITS  = 6,
  parameter int GS_BITS  = 12
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic sdata_o,
  input logic sclk_o,
  input logic latch_o,
  input logic prog_mode_o,
  input logic done_o
);
  localparam int DC_PULSES = CHANNELS * DC_BITS;
  localparam int GS_PULSES = CHANNELS * GS_BITS;

  logic [15:0] pcnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pcnt_q <= '0;
    else if (latch_o)               pcnt_q <= '0;
    else if (done_o && start_i)     pcnt_q <= '0;
    else if (sclk_o)                pcnt_q <= pcnt_q + 16'd1;
  end

  assert_dc_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_o && prog_mode_o) |-> (pcnt_q == 16'(DC_PULSES)));
  assert_gs_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_o && !prog_mode_o) |-> (pcnt_q == 16'(GS_PULSES)));
  assert_tail_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (pcnt_q == 16'd1));
  assert_sclk_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |=> !sclk_o);
  assert_latch_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |=> !latch_o);
  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_o && latch_o));
  assert_data_setup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata_o) |-> (!sclk_o && !$past(sclk_o)));
  assert_mode_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prog_mode_o) |-> (!sclk_o && !latch_o));
  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);
endmodule

bind led_drv_init_seq led_drv_init_seq_chk #(
  .CHANNELS(CHANNELS), .DC_BITS(DC_BITS), .GS_BITS(GS_BITS)
) i_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .sdata_o(sdata_o),
  .sclk_o(sclk_o), .latch_o(latch_o), .prog_mode_o(prog_mode_o), .done_o(done_o)
);

// File: tb/test_led_drv_init_seq.sv
module test_led_drv_init_seq;
  localparam int DC_N  = 96;
  localparam int GS_N  = 192;
  localparam int TOTAL = 2 * (DC_N + GS_N + 1) + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic sdata_o, sclk_o, latch_o, blank_o, prog_mode_o, dc_src_o, done_o;
  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  led_drv_init_seq i_led_drv_init_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sdata_o(sdata_o),
    .sclk_o(sclk_o), .latch_o(latch_o), .blank_o(blank_o),
    .prog_mode_o(prog_mode_o), .dc_src_o(dc_src_o), .done_o(done_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic t_reset();
    @(negedge clk);
    check("R1 blank", int'(blank_o), 1);
    check("R1 prog_mode", int'(prog_mode_o), 1);
    check("R1 dc_src", int'(dc_src_o), 1);
    check("R1 sdata", int'(sdata_o), 0);
    check("R1 sclk", int'(sclk_o), 0);
    check("R1 latch", int'(latch_o), 0);
    check("R1 done", int'(done_o), 0);
  endtask

  task automatic t_idle();
    int act = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sclk_o || latch_o || done_o) act++;
    end
    check("R1 idle without start", act, 0);
  endtask

  // Runs one sequence; restart_at > 0 raises start_i again at that cycle.
  task automatic t_sequence(input string tag, input int restart_at);
    int cyc = 0, done_cyc = 0, phase = 0;
    int dc_cnt = 0, gs_cnt = 0, tail_cnt = 0, bad_dc = 0, bad_gs = 0;
    int width_err = 0, data_err = 0, ctrl_err = 0, done_early = 0;
    logic p_sclk = 1'b0, p_latch = 1'b0, p_sdata;
    p_sdata = sdata_o;
    start_i = 1'b1;
    while (done_cyc == 0 && cyc < TOTAL + 50) begin
      @(negedge clk);
      cyc++;
      start_i = (restart_at > 0 && cyc == restart_at);
      if (cyc == 1) check({tag, " R8 done cleared by start"}, int'(done_o), 0);
      if (!blank_o || !dc_src_o) ctrl_err++;
      if ((p_sclk && sclk_o) || (p_latch && latch_o) || (sclk_o && latch_o)) width_err++;
      if ((sdata_o != p_sdata) && (sclk_o || p_sclk)) data_err++;
      if (sclk_o) begin
        if (phase == 0) begin dc_cnt++; if (!(sdata_o && prog_mode_o)) bad_dc++; end
        else if (phase == 1) begin gs_cnt++; if (sdata_o || prog_mode_o) bad_gs++; end
        else tail_cnt++;
      end
      if (latch_o) phase++;
      if (done_o) begin
        done_cyc = cyc;
        if (phase != 2) done_early++;
      end
      p_sclk = sclk_o; p_latch = latch_o; p_sdata = sdata_o;
    end
    start_i = 1'b0;
    check({tag, " R2 dc pulse count"}, dc_cnt, DC_N);
    check({tag, " R2 dc data/mode"}, bad_dc, 0);
    check({tag, " R3 gs pulse count"}, gs_cnt, GS_N);
    check({tag, " R3 gs data/mode"}, bad_gs, 0);
    check({tag, " R2 R3 latch count"}, phase, 2);
    check({tag, " R4 tail pulse"}, tail_cnt, 1);
    check({tag, " R4 done after latches"}, done_early, 0);
    check({tag, " R5 blank/dc_src held"}, ctrl_err, 0);
    check({tag, " R6 pulse shape"}, width_err, 0);
    check({tag, " R7 data changes only while low"}, data_err, 0);
    check({tag, " R8 done cycle"}, done_cyc, TOTAL + 1);
    tail_cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!done_o || sclk_o || latch_o || !blank_o) tail_cnt++;
    end
    check({tag, " R4 R8 quiet and done held"}, tail_cnt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle();
    t_sequence("first run", 0);
    t_sequence("R9 restart mid-sequence", 100);
    t_sequence("R9 restart near end", TOTAL - 3);
    t_sequence("R8 rerun after done", 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule